// File: doc/BRIEF.md
# Add/Subtract Flag ALU

A combinational integer datapath for the add/subtract family of a processor integer pipe. One opcode picks among plain add, add with carry, subtract, subtract with borrow, compare, negate, increment, decrement and exchange-add. A size select narrows the operation to a quarter, half or full datapath width (8, 16 or 32 bits by default). The block returns the result, a destination write strobe and, for exchange-add, a value for the source operand. It also returns six status flags (carry, zero, sign, overflow, auxiliary carry, parity), each with its own write strobe, and a vector of relational conditions decoded from the new flags.

The surrounding pipeline supplies the two operands, the current carry flag and an indication that the source operand is a byte immediate. It commits the result and the flags according to the strobes. Flags whose strobe is low keep their old value. On the carry output that old value is reflected from the carry input, so the condition decode is always taken from the flags as they stand after the operation.

Top module: `alu_flag_unit`

## Requirements
- R1: Size code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Operands are taken modulo the selected width, and result bits above that width are zero. Opcode 0 (add) yields dst+src and opcode 1 (add with carry) yields dst+src+carry_i.
- R2: Opcode 2 (subtract) yields dst-src and opcode 3 (subtract with borrow) yields dst-src-carry_i, both modulo the width.
- R3: Opcode 6 (increment) and opcode 7 (decrement) yield dst+1 and dst-1. Every flag is set as for an add or subtract of 1, except that cf_o equals carry_i and flag_we_o bit 0 is low.
- R4: Opcode 4 (compare) sets the flags exactly as subtract does, but dst_we_o is low.
- R5: For add forms, carry is the carry out of the top bit of the width. For subtract forms, carry is set exactly when an unsigned borrow occurs, that is when dst is below src (plus carry-in for opcode 3).
- R6: Overflow is set exactly when the signed value of the true result lies outside the signed range of the selected width.
- R7: Zero is set for an all-zero result. Sign is the top result bit. Parity is set when result bits 7:0 hold an even number of ones. Auxiliary carry is the carry (add) or borrow (subtract) out of bit 3.
- R8: Opcode 5 (negate) yields 0-dst. Carry is clear only for a zero operand. Negating the most negative value returns it unchanged with overflow set.
- R9: Opcode 8 (exchange-add) writes dst+src with add flags, asserts src_we_o, and returns the original dst, masked to the width, on src_wb_o. No other opcode asserts src_we_o.
- R10: With imm8_i high, src bits 7:0 are sign-extended to the selected width before use.
- R11: cond_o bits are: 0 equal, 1 not equal, 2 unsigned below, 3 unsigned below-or-equal, 4 unsigned above, 5 unsigned above-or-equal, 6 signed less, 7 signed less-or-equal, 8 signed greater, 9 signed greater-or-equal. Signed less is sign XOR overflow. After a compare they match the relation of dst to src.
- R12: flag_we_o bits are carry 0, zero 1, sign 2, overflow 3, aux 4, parity 5. All six are high for opcodes 0 to 8, except bit 0 for opcodes 6 and 7. For opcodes 9 to 15, flag_we_o, dst_we_o and src_we_o are all low and cf_o equals carry_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand width select |
| imm8_i | input | 1 | Source is a sign-extended byte immediate |
| carry_i | input | 1 | Current carry flag |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| result_o | output | 32 | Operation result, zero above the width |
| dst_we_o | output | 1 | Destination write strobe |
| src_wb_o | output | 32 | Value for the source operand (exchange-add) |
| src_we_o | output | 1 | Source write strobe |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| af_o | output | 1 | Auxiliary carry flag |
| pf_o | output | 1 | Parity flag |
| flag_we_o | output | 6 | Per-flag write strobes |
| cond_o | output | 10 | Decoded relational conditions |

## Verification
Every output is a pure function of the current inputs, so each result is due zero cycles after its stimulus, with no register on any path. The bench changes inputs shortly after a rising edge and samples all outputs at the following falling edge. That leaves half a period for the carry chain to settle, and it never samples while inputs are moving. The 8-bit width is swept exhaustively in dst against a spread of src values, both carry-in states and every opcode. The wider widths use boundary operands around zero, the sign bit and the all-ones value.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_NEG  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_XADD = 4'd8
  } alu_op_e;

  localparam int NFLAGS = 6;
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_S = 2;
  localparam int F_O = 3;
  localparam int F_A = 4;
  localparam int F_P = 5;

  localparam int NCOND = 10;
  localparam int C_EQ  = 0;
  localparam int C_NE  = 1;
  localparam int C_ULT = 2;
  localparam int C_ULE = 3;
  localparam int C_UGT = 4;
  localparam int C_UGE = 5;
  localparam int C_SLT = 6;
  localparam int C_SLE = 7;
  localparam int C_SGT = 8;
  localparam int C_SGE = 9;

  localparam int NLANES = 3;

  typedef struct packed {
    logic valid;
    logic do_sub;
    logic use_cin;
    logic zero_a;
    logic one_b;
    logic wr_dst;
    logic wr_src;
    logic keep_cf;
  } alu_ctl_t;

  function automatic int lane_width(int xlen, int k);
    return (k == 0) ? xlen / 4 : (k == 1) ? xlen / 2 : xlen;
  endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (op_i)
      OP_ADD:  begin ctl_o.valid = 1'b1; ctl_o.wr_dst = 1'b1; end
      OP_ADC:  begin ctl_o.valid = 1'b1; ctl_o.wr_dst = 1'b1; ctl_o.use_cin = 1'b1; end
      OP_SUB:  begin ctl_o.valid = 1'b1; ctl_o.wr_dst = 1'b1; ctl_o.do_sub = 1'b1; end
      OP_SBB:  begin
        ctl_o.valid = 1'b1; ctl_o.wr_dst = 1'b1;
        ctl_o.do_sub = 1'b1; ctl_o.use_cin = 1'b1;
      end
      OP_CMP:  begin ctl_o.valid = 1'b1; ctl_o.do_sub = 1'b1; end
      OP_NEG:  begin
        ctl_o.valid = 1'b1; ctl_o.wr_dst = 1'b1;
        ctl_o.do_sub = 1'b1; ctl_o.zero_a = 1'b1;
      end
      OP_INC:  begin
        ctl_o.valid = 1'b1; ctl_o.wr_dst = 1'b1;
        ctl_o.one_b = 1'b1; ctl_o.keep_cf = 1'b1;
      end
      OP_DEC:  begin
        ctl_o.valid = 1'b1; ctl_o.wr_dst = 1'b1; ctl_o.do_sub = 1'b1;
        ctl_o.one_b = 1'b1; ctl_o.keep_cf = 1'b1;
      end
      OP_XADD: begin ctl_o.valid = 1'b1; ctl_o.wr_dst = 1'b1; ctl_o.wr_src = 1'b1; end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_opnd_prep.sv
module alu_opnd_prep
  import alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 8
) (
  input  logic [1:0]        size_i,
  input  logic              imm_i,
  input  logic              zero_a_i,
  input  logic              one_b_i,
  input  logic [XLEN-1:0]   dst_i,
  input  logic [XLEN-1:0]   src_i,
  output logic [XLEN-1:0]   mask_o,
  output logic [NLANES-1:0] wsel_o,
  output logic [XLEN-1:0]   dmask_o,
  output logic [XLEN-1:0]   x_o,
  output logic [XLEN-1:0]   y_o
);

  localparam int QW = XLEN / 4;
  localparam int HW = XLEN / 2;

  logic [XLEN-1:0] src_ext;
  logic [XLEN-1:0] src_m;

  always_comb begin
    case (size_i)
      2'd0: begin
        wsel_o = 3'b001;
        mask_o = {{(XLEN-QW){1'b0}}, {QW{1'b1}}};
      end
      2'd1: begin
        wsel_o = 3'b010;
        mask_o = {{(XLEN-HW){1'b0}}, {HW{1'b1}}};
      end
      default: begin
        wsel_o = 3'b100;
        mask_o = {XLEN{1'b1}};
      end
    endcase
  end

  assign src_ext = imm_i ? {{(XLEN-IMM_W){src_i[IMM_W-1]}}, src_i[IMM_W-1:0]} : src_i;
  assign dmask_o = dst_i & mask_o;
  assign src_m   = src_ext & mask_o;

  always_comb begin
    if (zero_a_i) begin
      x_o = '0;
      y_o = dmask_o;
    end else begin
      x_o = dmask_o;
      y_o = one_b_i ? XLEN'(1) : src_m;
    end
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   x_i,
  input  logic [XLEN-1:0]   y_i,
  input  logic [XLEN-1:0]   mask_i,
  input  logic [NLANES-1:0] wsel_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [XLEN-1:0]   res_o,
  output logic              cout_o,
  output logic              ovf_o,
  output logic              aux_o
);

  localparam int AUX_BIT = 4;

  logic [XLEN-1:0]   yy;
  logic              ci;
  logic [XLEN:0]     sum;
  logic [NLANES-1:0] lane_c;
  logic [NLANES-1:0] lane_v;
  logic              cout_raw;

  assign yy  = sub_i ? (~y_i & mask_i) : y_i;
  assign ci  = sub_i ^ cin_i;
  assign sum = {1'b0, x_i} + {1'b0, yy} + {{XLEN{1'b0}}, ci};

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    localparam int W = lane_width(XLEN, k);
    assign lane_c[k] = sum[W];
    assign lane_v[k] = (x_i[W-1] ^ sum[W-1]) & (yy[W-1] ^ sum[W-1]);
  end

  assign cout_raw = |(lane_c & wsel_i);
  assign cout_o   = sub_i ? ~cout_raw : cout_raw;
  assign ovf_o    = |(lane_v & wsel_i);
  assign aux_o    = x_i[AUX_BIT] ^ y_i[AUX_BIT] ^ sum[AUX_BIT];
  assign res_o    = sum[XLEN-1:0] & mask_i;

endmodule

// File: rtl/alu_status_gen.sv
module alu_status_gen
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   res_i,
  input  logic [NLANES-1:0] wsel_i,
  input  logic              cf_i,
  input  logic              of_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o,
  output logic [NCOND-1:0]  cond_o
);

  logic [NLANES-1:0] lane_s;
  logic              lt;
  logic              be;

  for (genvar k = 0; k < NLANES; k++) begin : g_sign
    localparam int W = lane_width(XLEN, k);
    assign lane_s[k] = res_i[W-1];
  end

  assign zf_o = (res_i == '0);
  assign sf_o = |(lane_s & wsel_i);
  assign pf_o = ~^res_i[7:0];

  assign lt = sf_o ^ of_i;
  assign be = cf_i | zf_o;

  always_comb begin
    cond_o        = '0;
    cond_o[C_EQ]  = zf_o;
    cond_o[C_NE]  = ~zf_o;
    cond_o[C_ULT] = cf_i;
    cond_o[C_ULE] = be;
    cond_o[C_UGT] = ~be;
    cond_o[C_UGE] = ~cf_i;
    cond_o[C_SLT] = lt;
    cond_o[C_SLE] = lt | zf_o;
    cond_o[C_SGT] = ~(lt | zf_o);
    cond_o[C_SGE] = ~lt;
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              imm8_i,
  input  logic              carry_i,
  input  logic [XLEN-1:0]   dst_i,
  input  logic [XLEN-1:0]   src_i,
  output logic [XLEN-1:0]   result_o,
  output logic              dst_we_o,
  output logic [XLEN-1:0]   src_wb_o,
  output logic              src_we_o,
  output logic              cf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic              af_o,
  output logic              pf_o,
  output logic [NFLAGS-1:0] flag_we_o,
  output logic [NCOND-1:0]  cond_o
);

  alu_ctl_t          ctl;
  logic [XLEN-1:0]   mask;
  logic [NLANES-1:0] wsel;
  logic [XLEN-1:0]   dmask;
  logic [XLEN-1:0]   x;
  logic [XLEN-1:0]   y;
  logic              cout;

  alu_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  alu_opnd_prep #(.XLEN(XLEN)) u_prep (
    .size_i   (size_i),
    .imm_i    (imm8_i),
    .zero_a_i (ctl.zero_a),
    .one_b_i  (ctl.one_b),
    .dst_i    (dst_i),
    .src_i    (src_i),
    .mask_o   (mask),
    .wsel_o   (wsel),
    .dmask_o  (dmask),
    .x_o      (x),
    .y_o      (y)
  );

  alu_addsub #(.XLEN(XLEN)) u_core (
    .x_i    (x),
    .y_i    (y),
    .mask_i (mask),
    .wsel_i (wsel),
    .sub_i  (ctl.do_sub),
    .cin_i  (ctl.use_cin & carry_i),
    .res_o  (result_o),
    .cout_o (cout),
    .ovf_o  (of_o),
    .aux_o  (af_o)
  );

  assign cf_o = (ctl.keep_cf | ~ctl.valid) ? carry_i : cout;

  alu_status_gen #(.XLEN(XLEN)) u_stat (
    .res_i  (result_o),
    .wsel_i (wsel),
    .cf_i   (cf_o),
    .of_i   (of_o),
    .zf_o   (zf_o),
    .sf_o   (sf_o),
    .pf_o   (pf_o),
    .cond_o (cond_o)
  );

  assign dst_we_o  = ctl.wr_dst;
  assign src_we_o  = ctl.wr_src;
  assign src_wb_o  = dmask;
  assign flag_we_o = ctl.valid ? {{(NFLAGS-1){1'b1}}, ~ctl.keep_cf} : '0;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [3:0]        op_i,
  input logic [1:0]        size_i,
  input logic              carry_i,
  input logic [XLEN-1:0]   dst_i,
  input logic [XLEN-1:0]   result_o,
  input logic              dst_we_o,
  input logic [XLEN-1:0]   src_wb_o,
  input logic              src_we_o,
  input logic              cf_o,
  input logic              zf_o,
  input logic [NFLAGS-1:0] flag_we_o
);

  logic [XLEN-1:0] m;

  always_comb begin
    case (size_i)
      2'd0:    m = {{(XLEN-XLEN/4){1'b0}}, {(XLEN/4){1'b1}}};
      2'd1:    m = {{(XLEN-XLEN/2){1'b0}}, {(XLEN/2){1'b1}}};
      default: m = {XLEN{1'b1}};
    endcase
  end

  always_comb begin
    p_width_r1: assert ((result_o & ~m) == '0)
      else $error("result has bits above the selected width");
    p_keep_cf_r3: assert (!(op_i == 4'd6 || op_i == 4'd7) ||
                          (cf_o == carry_i && !flag_we_o[F_C]))
      else $error("inc/dec disturbed carry");
    p_cmp_nostore_r4: assert (op_i != 4'd4 || !dst_we_o)
      else $error("compare wrote destination");
    p_zero_r7: assert (zf_o == (result_o == '0))
      else $error("zero flag disagrees with result");
    p_neg_carry_r8: assert (op_i != 4'd5 || cf_o == ((dst_i & m) != '0))
      else $error("negate carry wrong");
    p_xadd_old_r9: assert (op_i != 4'd8 || (src_we_o && src_wb_o == (dst_i & m)))
      else $error("exchange-add old value wrong");
    p_srcwe_only_r9: assert (op_i == 4'd8 || !src_we_o)
      else $error("source written by non exchange-add");
    p_idle_r12: assert (op_i <= 4'd8 ||
                        (flag_we_o == '0 && !dst_we_o && !src_we_o && cf_o == carry_i))
      else $error("unused opcode had an effect");
  end

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [1:0]  size_i;
  logic        imm8_i;
  logic        carry_i;
  logic [31:0] dst_i;
  logic [31:0] src_i;
  logic [31:0] result_o;
  logic        dst_we_o;
  logic [31:0] src_wb_o;
  logic        src_we_o;
  logic        cf_o, zf_o, sf_o, of_o, af_o, pf_o;
  logic [5:0]  flag_we_o;
  logic [9:0]  cond_o;

  int n_vec;
  int n_bad;
  bit done;

  alu_flag_unit u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint sx(longint v, int w);
    return ((v >> (w - 1)) & 1) != 0 ? v - (longint'(1) << w) : v;
  endfunction

  function automatic bit inrange(longint s, int w);
    return (s >= -(longint'(1) << (w - 1))) && (s < (longint'(1) << (w - 1)));
  endfunction

  function automatic longint corner(int k, int w);
    longint msk;
    longint hp;
    msk = (longint'(1) << w) - 1;
    hp  = longint'(1) << (w - 1);
    case (k)
      0: return 0;
      1: return 1;
      2: return 15;
      3: return 16;
      4: return 127;
      5: return 128;
      6: return 255;
      7: return hp - 1;
      8: return hp;
      9: return hp + 1;
      10: return msk - 1;
      default: return msk;
    endcase
  endfunction

  function automatic longint small8(int k);
    case (k)
      0: return 0;   1: return 1;   2: return 2;   3: return 7;
      4: return 8;   5: return 9;   6: return 15;  7: return 16;
      8: return 63;  9: return 64;  10: return 126; 11: return 127;
      12: return 128; 13: return 129; 14: return 254; default: return 255;
    endcase
  endfunction

  task automatic cmp1(string req, string what, longint act, longint exp, ref bit bad);
    if (act != exp) begin
      $display("FAIL %s %s op=%0d size=%0d dst=%h src=%h c=%0d imm=%0d: actual %h expected %h",
               req, what, op_i, size_i, dst_i, src_i, carry_i, imm8_i, act, exp);
      bad = 1'b1;
    end
  endtask

  task automatic apply(int op, int sz, longint a, longint b, bit imm, bit c);
    int     w;
    longint msk, av, bv, opnd, full, s, r;
    bit     ecf, eof, eaf, valid, kc;
    bit     bad;
    string  rq;
    @(posedge clk);
    #2;
    op_i    = 4'(op);
    size_i  = 2'(sz);
    imm8_i  = imm;
    carry_i = c;
    dst_i   = 32'(a);
    src_i   = 32'(b);
    @(negedge clk);
    w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    msk = (longint'(1) << w) - 1;
    av  = a & msk;
    bv  = imm ? (((b & 255) >= 128) ? ((b & 255) - 256) : (b & 255)) & msk : b & msk;
    valid = (op <= 8);
    kc    = (op == 6 || op == 7);
    bad = 1'b0;
    ecf = 0; eof = 0; eaf = 0; r = 0;
    case (op)
      0, 1, 6, 8: begin
        opnd = (op == 6) ? 1 : bv;
        full = av + opnd + ((op == 1) ? longint'(c) : 0);
        r    = full & msk;
        ecf  = ((full >> w) & 1) != 0;
        s    = sx(av, w) + sx(opnd, w) + ((op == 1) ? longint'(c) : 0);
        eof  = !inrange(s, w);
        eaf  = ((av & 15) + (opnd & 15) + ((op == 1) ? longint'(c) : 0)) > 15;
      end
      2, 3, 4, 7: begin
        opnd = (op == 7) ? 1 : bv;
        full = av - opnd - ((op == 3) ? longint'(c) : 0);
        r    = full & msk;
        ecf  = full < 0;
        s    = sx(av, w) - sx(opnd, w) - ((op == 3) ? longint'(c) : 0);
        eof  = !inrange(s, w);
        eaf  = (av & 15) < ((opnd & 15) + ((op == 3) ? longint'(c) : 0));
      end
      5: begin
        r   = (0 - av) & msk;
        ecf = av != 0;
        eof = !inrange(-sx(av, w), w);
        eaf = (av & 15) != 0;
      end
      default: ;
    endcase
    if (kc) ecf = c;
    case (op)
      0, 1: rq = "R1"; 2, 3: rq = "R2"; 4: rq = "R4"; 5: rq = "R8";
      6, 7: rq = "R3"; 8: rq = "R9"; default: rq = "R12";
    endcase
    if (imm && op <= 4) rq = {rq, "/R10"};
    n_vec++;
    if (valid) begin
      cmp1(rq, "result", result_o, r, bad);
      cmp1("R5", "cf", cf_o, ecf, bad);
      cmp1("R6", "of", of_o, eof, bad);
      cmp1("R7", "af", af_o, eaf, bad);
      cmp1("R7", "zf", zf_o, r == 0, bad);
      cmp1("R7", "sf", sf_o, (r >> (w - 1)) & 1, bad);
      cmp1("R7", "pf", pf_o, ($countones(8'(r)) % 2) == 0, bad);
      cmp1("R12", "flag_we", flag_we_o, kc ? 6'b111110 : 6'b111111, bad);
      cmp1("R4", "dst_we", dst_we_o, op != 4, bad);
      cmp1("R9", "src_we", src_we_o, op == 8, bad);
      if (op == 8) cmp1("R9", "src_wb", src_wb_o, av, bad);
      if (op == 4) begin
        longint sa, sb;
        logic [9:0] ec;
        sa = sx(av, w); sb = sx(bv, w);
        ec = {sa >= sb, sa > sb, sa <= sb, sa < sb,
              av >= bv, av > bv, av <= bv, av < bv, av != bv, av == bv};
        cmp1("R11", "cond", cond_o, ec, bad);
      end
    end else begin
      cmp1("R12", "flag_we", flag_we_o, 0, bad);
      cmp1("R12", "dst_we", dst_we_o, 0, bad);
      cmp1("R12", "src_we", src_we_o, 0, bad);
      cmp1("R12", "cf", cf_o, c, bad);
    end
    if (bad) n_bad++;
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0;
    op_i = '0; size_i = '0; imm8_i = 1'b0; carry_i = 1'b0; dst_i = '0; src_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: zero operands, plain add
    apply(0, 0, 0, 0, 0, 0);
    // 8-bit: exhaustive dst against a spread of src, every opcode, both carries
    for (int op = 0; op <= 8; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          for (int k = 0; k < 16; k++)
            apply(op, 0, a, small8(k), 0, c[0]);
    // wide widths: boundary operands, with and without byte immediate (R10)
    for (int sz = 1; sz <= 3; sz++)
      for (int op = 0; op <= 8; op++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++)
            for (int f = 0; f < 4; f++)
              apply(op, sz, corner(i, (sz == 1) ? 16 : 32),
                    corner(j, (sz == 1) ? 16 : 32), f[1], f[0]);
    // R8: most negative value at each width
    apply(5, 0, 32'h80, 0, 0, 0);
    apply(5, 1, 32'h8000, 0, 0, 1);
    apply(5, 2, 32'h8000_0000, 0, 0, 0);
    // R11: worked signed-compare cases at 16 bits
    apply(4, 1, 32'hFFFF, 32'hFFFE, 0, 0);
    apply(4, 1, 32'h8000, 32'h0001, 0, 0);
    apply(4, 1, 32'hFFFE, 32'hFFFF, 0, 0);
    apply(4, 1, 32'h7FFF, 32'hFFFF, 0, 0);
    // R12: unused opcodes
    for (int op = 9; op < 16; op++)
      for (int c = 0; c < 2; c++)
        apply(op, 2, 32'h1234_5678, 32'hFFFF_0001, 0, c[0]);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule